// File: doc/BRIEF.md
# Transmit Frame Timing Generator

This block produces the byte-level frame timing for a 155.52 Mbit/s SONET/SDH transmit byte bus that runs on a 19.44 MHz byte clock. Two counters give the row and the byte column of the byte on the bus in every clock period. A one-clock strobe marks the first byte of each frame. A payload indicator goes low while the byte is Transport Overhead and goes high for every other byte.

With no external reference, the block free-runs and starts a new 2430-byte frame every 125 µs on its own. A system that must hold several transmitters in phase supplies an 8 kHz sync pulse, one byte clock wide and synchronous to the byte clock. The block takes the rising edge of that pulse, waits a programmable number of clocks, and then forces the counters to the first byte of a frame. If pulses keep arriving in phase with the running count, they confirm the alignment and do not disturb the timing.

Top module: `frame_timing_gen`

## Requirements
- R1: A synchronous reset (`rst` high) sets row and column to 0 and clears any pending alignment. After `rst` is released, the first output period shows row 0, column 0, and the block then free-runs.
- R2: When no alignment is forced, the column increments by one each clock and stays in the range 0 to COLS-1. The row holds its value while the column is non-zero.
- R3: When the column wraps from COLS-1 to 0, the row increments by one, and the row wraps from ROWS-1 to 0. With `sync_in` held low, frames repeat every ROWS*COLS clocks (2430 by default).
- R4: `payload` is 0 while the column is below OH_COLS (columns 0 to 8 by default) and 1 for every other column.
- R5: `sof` is 1 only in the clock period whose row and column are both 0, so it lasts exactly one clock per frame.
- R6: A sync edge is a clock edge at which `sync_in` is 1 and was 0 at the previous clock edge. If a sync edge is sampled at clock edge k with `sync_delay` = D, the outputs show row 0, column 0 right after clock edge k+D. D = 0 means right after edge k, and D may be larger than a frame.
- R7: Only the rising edge counts. Holding `sync_in` high for several clocks causes one alignment, and the counters then keep running.
- R8: Sync edges that arrive every ROWS*COLS clocks, in phase with the current frame, leave the timing unchanged: `sof` keeps its 2430-clock period.
- R9: A new sync edge that arrives while an earlier delay is still counting restarts the delay from the new edge, using the `sync_delay` value sampled at that edge. The earlier edge then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.44 MHz byte clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | 8 kHz frame sync pulse, synchronous to `clk` |
| sync_delay | input | DLY_W | Clocks from the sampled sync edge to the forced frame start |
| row | output | clog2(ROWS) | Row of the current byte |
| col | output | clog2(COLS) | Column of the current byte |
| sof | output | 1 | Start-of-frame strobe at row 0, column 0 |
| payload | output | 1 | 1 for payload bytes, 0 for Transport Overhead bytes |

## Verification
The bench builds the block with its default parameters: 9 rows of 270 columns, 9 overhead columns, a 12-bit delay and the delay path enabled. At these sizes the full free-running frame is short enough to watch wrap completely. The 12-bit delay also reaches a 3000-clock offset, which is longer than a frame. Sync bursts are timed by hand to land exactly one frame apart, and a second edge is sent 20 clocks into a 200-clock delay. This exercises both the confirming path and the restart path against a model that counts absolute clock numbers.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

   // Alignment tracker state: idle, or counting down a delay after a sync edge
   typedef enum logic [0:0] {
      ALIGN_IDLE = 1'b0,
      ALIGN_WAIT = 1'b1
   } align_state_e;

   // Counter width for a modulus, never narrower than one bit
   function automatic int ftg_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ftg_sync_align.sv
module ftg_sync_align #(
   parameter int DLY_W     = 12,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_in,
   input  logic [DLY_W-1:0] delay_cfg,
   output logic             sync_edge,
   output logic             force_start
);
   import ftg_pkg::*;

   localparam logic [DLY_W-1:0] DLY_ZERO = '0;
   localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

   initial begin : chk_params
      if (DLY_W < 1)  $error("ftg_sync_align: DLY_W must be at least 1");
      if (DLY_W > 24) $error("ftg_sync_align: DLY_W above 24 is not supported");
   end

   logic sync_q;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= 1'b0;
      else     sync_q <= sync_in;
   end

   // The input is synchronous to clk, so it is compared directly
   assign sync_edge = sync_in & ~sync_q;

   generate
      if (USE_DELAY) begin : g_delay
         align_state_e     state_q;
         logic [DLY_W-1:0] remain_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               state_q  <= ALIGN_IDLE;
               remain_q <= DLY_ZERO;
            end else if (sync_edge) begin
               // A fresh edge always restarts the countdown
               if (delay_cfg == DLY_ZERO) begin
                  state_q  <= ALIGN_IDLE;
                  remain_q <= DLY_ZERO;
               end else begin
                  state_q  <= ALIGN_WAIT;
                  remain_q <= delay_cfg;
               end
            end else if (state_q == ALIGN_WAIT) begin
               if (remain_q == DLY_ONE) state_q <= ALIGN_IDLE;
               remain_q <= remain_q - DLY_ONE;
            end
         end

         assign force_start = sync_edge ? (delay_cfg == DLY_ZERO)
                                        : ((state_q == ALIGN_WAIT) && (remain_q == DLY_ONE));
      end else begin : g_direct
         logic unused_cfg;
         assign unused_cfg  = ^delay_cfg;
         assign force_start = sync_edge;
      end
   endgenerate

endmodule

// File: rtl/ftg_counter.sv
module ftg_counter #(
   parameter int ROWS = 9,
   parameter int COLS = 270,
   localparam int RW = ftg_pkg::ftg_bits(ROWS),
   localparam int CW = ftg_pkg::ftg_bits(COLS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          force_start,
   output logic [RW-1:0] row,
   output logic [CW-1:0] col
);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
   localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
   localparam logic [RW-1:0] ROW_ONE  = RW'(1);
   localparam logic [CW-1:0] COL_ONE  = CW'(1);

   logic [RW-1:0] row_q, row_d;
   logic [CW-1:0] col_q, col_d;
   logic          col_wrap;

   assign col_wrap = (col_q == COL_LAST);

   always_comb begin
      row_d = row_q;
      col_d = col_q + COL_ONE;
      if (col_wrap) begin
         col_d = '0;
         row_d = (row_q == ROW_LAST) ? '0 : row_q + ROW_ONE;
      end
      if (force_start) begin
         row_d = '0;
         col_d = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= '0;
         col_q <= '0;
      end else begin
         row_q <= row_d;
         col_q <= col_d;
      end
   end

   assign row = row_q;
   assign col = col_q;

endmodule

// File: rtl/ftg_decode.sv
module ftg_decode #(
   parameter int ROWS    = 9,
   parameter int COLS    = 270,
   parameter int OH_COLS = 9,
   localparam int RW = ftg_pkg::ftg_bits(ROWS),
   localparam int CW = ftg_pkg::ftg_bits(COLS)
) (
   input  logic [RW-1:0] row,
   input  logic [CW-1:0] col,
   output logic          sof,
   output logic          payload
);
   assign sof = (row == '0) && (col == '0);

   generate
      if (OH_COLS == 0) begin : g_no_oh
         assign payload = 1'b1;
      end else begin : g_oh
         localparam logic [CW-1:0] OH_END = CW'(OH_COLS);
         assign payload = (col >= OH_END);
      end
   endgenerate

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen #(
   parameter int ROWS      = 9,
   parameter int COLS      = 270,
   parameter int OH_COLS   = 9,
   parameter int DLY_W     = 12,
   parameter bit USE_DELAY = 1'b1,
   localparam int RW = ftg_pkg::ftg_bits(ROWS),
   localparam int CW = ftg_pkg::ftg_bits(COLS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_in,
   input  logic [DLY_W-1:0] sync_delay,
   output logic [RW-1:0]    row,
   output logic [CW-1:0]    col,
   output logic             sof,
   output logic             payload
);
   initial begin : chk_params
      if (ROWS < 2)           $error("frame_timing_gen: ROWS must be at least 2");
      if (COLS < 2)           $error("frame_timing_gen: COLS must be at least 2");
      if (OH_COLS < 0)        $error("frame_timing_gen: OH_COLS must not be negative");
      if (OH_COLS >= COLS)    $error("frame_timing_gen: OH_COLS must leave payload columns");
   end

   logic sync_edge;
   logic force_start;

   ftg_sync_align #(
      .DLY_W     (DLY_W),
      .USE_DELAY (USE_DELAY)
   ) i_align (
      .clk         (clk),
      .rst         (rst),
      .sync_in     (sync_in),
      .delay_cfg   (sync_delay),
      .sync_edge   (sync_edge),
      .force_start (force_start)
   );

   ftg_counter #(
      .ROWS (ROWS),
      .COLS (COLS)
   ) i_counter (
      .clk         (clk),
      .rst         (rst),
      .force_start (force_start),
      .row         (row),
      .col         (col)
   );

   ftg_decode #(
      .ROWS    (ROWS),
      .COLS    (COLS),
      .OH_COLS (OH_COLS)
   ) i_decode (
      .row     (row),
      .col     (col),
      .sof     (sof),
      .payload (payload)
   );

endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
   parameter int ROWS    = 9,
   parameter int COLS    = 270,
   parameter int OH_COLS = 9,
   localparam int RW = ftg_pkg::ftg_bits(ROWS),
   localparam int CW = ftg_pkg::ftg_bits(COLS)
) (
   input logic          clk,
   input logic          rst,
   input logic          sync_in,
   input logic          sync_edge,
   input logic          force_start,
   input logic [RW-1:0] row,
   input logic [CW-1:0] col,
   input logic          sof,
   input logic          payload
);
   localparam logic [RW-1:0] ROW_LIM  = RW'(ROWS);
   localparam logic [CW-1:0] COL_LIM  = CW'(COLS);
   localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
   localparam logic [CW-1:0] OH_END   = CW'(OH_COLS);

   logic live_q;
   always_ff @(posedge clk) begin
      if (rst) live_q <= 1'b0;
      else     live_q <= 1'b1;
   end

   AST_RESET_ORIGIN: assert property (@(posedge clk) $fell(rst) |-> (row == '0 && col == '0)); // R1
   AST_COL_RANGE:    assert property (@(posedge clk) disable iff (rst) col < COL_LIM); // R2
   AST_COL_STEP:     assert property (@(posedge clk) disable iff (rst)
                        (live_q && col != '0) |-> (col == $past(col) + CW'(1))); // R2
   AST_ROW_HOLD:     assert property (@(posedge clk) disable iff (rst)
                        (live_q && col != '0) |-> (row == $past(row))); // R2
   AST_ROW_RANGE:    assert property (@(posedge clk) disable iff (rst) row < ROW_LIM); // R3
   AST_ROW_STEP:     assert property (@(posedge clk) disable iff (rst)
                        (live_q && col == '0 && row != '0) |->
                        ($past(col) == COL_LAST && row == $past(row) + RW'(1))); // R3
   AST_PAYLOAD_OH:   assert property (@(posedge clk) disable iff (rst)
                        (col < OH_END) |-> !payload); // R4
   AST_SOF_SINGLE:   assert property (@(posedge clk) disable iff (rst) sof |=> !sof); // R5
   AST_FORCE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
                        force_start |=> (sof && row == '0 && col == '0)); // R6
   AST_LEVEL_ONCE:   assert property (@(posedge clk) disable iff (rst)
                        (live_q && $past(sync_in) && sync_in) |-> !sync_edge); // R7

endmodule

bind frame_timing_gen ftg_checker #(
   .ROWS    (ROWS),
   .COLS    (COLS),
   .OH_COLS (OH_COLS)
) i_ftg_checker (
   .clk         (clk),
   .rst         (rst),
   .sync_in     (sync_in),
   .sync_edge   (sync_edge),
   .force_start (force_start),
   .row         (row),
   .col         (col),
   .sof         (sof),
   .payload     (payload)
);

// File: tb/test_frame_timing_gen.sv
module test_frame_timing_gen;
   localparam int ROWS  = 9;
   localparam int COLS  = 270;
   localparam int OH    = 9;
   localparam int DLY_W = 12;
   localparam int FRAME = ROWS * COLS;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             sync_in = 1'b0;
   logic [DLY_W-1:0] dly = '0;
   logic [3:0]       row;
   logic [8:0]       col;
   logic             sof;
   logic             payload;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   // behavioural reference: absolute clock numbers, target clock for alignment
   int m_row = 0, m_col = 0, m_target = -1;
   bit m_prev = 1'b0;

   frame_timing_gen i_frame_timing_gen (
      .clk        (clk),
      .rst        (rst),
      .sync_in    (sync_in),
      .sync_delay (dly),
      .row        (row),
      .col        (col),
      .sof        (sof),
      .payload    (payload)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (clock %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_row = 0; m_col = 0; m_target = -1; m_prev = 1'b0;
      end else begin
         if (sync_in && !m_prev) m_target = cyc + int'(dly);
         m_prev = sync_in;
         if (cyc == m_target) begin
            m_row = 0; m_col = 0; m_target = -1;
         end else begin
            m_col++;
            if (m_col == COLS) begin
               m_col = 0;
               m_row = (m_row + 1) % ROWS;
            end
         end
      end
      cyc++;
   end

   always @(negedge clk) begin
      if (!rst) begin
         chk("R2 column vs model", int'(col), m_col);
         chk("R3 row vs model", int'(row), m_row);
         chk("R4 payload vs model", int'(payload), (m_col >= OH) ? 1 : 0);
         chk("R5 sof vs model", int'(sof), (m_row == 0 && m_col == 0) ? 1 : 0);
      end
   end

   task automatic pulse();
      @(negedge clk) sync_in = 1'b1;
      @(negedge clk) sync_in = 1'b0;
   endtask

   task automatic at_origin(input string tag);
      chk({tag, " row"}, int'(row), 0);
      chk({tag, " col"}, int'(col), 0);
      chk({tag, " sof"}, int'(sof), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      at_origin("R1 after reset");
      chk("R1 payload in overhead", int'(payload), 0);

      // free run: one full frame returns to the origin
      repeat (FRAME) @(negedge clk);
      at_origin("R3 free-run frame period");
      repeat (OH) @(negedge clk);
      chk("R4 first payload column", int'(payload), 1);

      // zero delay
      repeat (137) @(negedge clk);
      dly = '0;
      pulse();
      at_origin("R6 delay 0");

      // mid delay
      repeat (500) @(negedge clk);
      dly = 12'd100;
      pulse();
      repeat (100) @(negedge clk);
      at_origin("R6 delay 100");

      // delay longer than one frame
      repeat (77) @(negedge clk);
      dly = 12'd3000;
      pulse();
      repeat (3000) @(negedge clk);
      at_origin("R6 delay 3000");

      // level held high: one alignment only
      repeat (333) @(negedge clk);
      dly = '0;
      @(negedge clk) sync_in = 1'b1;
      @(negedge clk);
      at_origin("R7 level start");
      repeat (50) @(negedge clk);
      chk("R7 held level col", int'(col), 50);
      chk("R7 held level row", int'(row), 0);
      sync_in = 1'b0;

      // in-phase periodic pulses confirm timing
      repeat (211) @(negedge clk);
      dly = 12'd10;
      pulse();
      repeat (10) @(negedge clk);
      at_origin("R8 initial alignment");
      for (int i = 0; i < 3; i++) begin
         repeat (FRAME - 12) @(negedge clk);
         pulse();
         repeat (10) @(negedge clk);
         at_origin("R8 periodic pulse");
      end

      // restart of a pending delay
      repeat (1234) @(negedge clk);
      dly = 12'd200;
      pulse();
      repeat (20) @(negedge clk);
      pulse();
      repeat (200) @(negedge clk);
      at_origin("R9 restarted delay");

      repeat (40) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

endmodule